// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a synchronous host and a byte-wide asynchronous static RAM. The host issues single-beat reads and writes through a request/ready handshake. The controller then produces the active-low chip-select, output-enable and write-enable strobes, the address, and a split data path: data out, a drive enable for the pad, and data in. It returns read data together with a one-cycle completion pulse.

Every strobe width is derived when the design is elaborated. Each memory timing figure is given in picoseconds together with the clock period. Each figure becomes a cycle count: the figure divided by the period, rounded up. Where several figures limit the same window, the largest count wins.

A chip-select-high idle cycle separates every pair of accesses. After a write there is also a turnaround interval before the next access can start. During that interval nothing drives the data bus, so the controller and the memory never drive it at the same time.

Top module: `sram_bus_ctrl`

## Requirements
- R1: During and right after reset, cs_n_o, oe_n_o and we_n_o are 1, mem_dout_en_o is 0, ready_o is 1 and done_o is 0.
- R2: A read accepted on a clock edge with req_i=1, ready_o=1 and wr_i=0 holds cs_n_o=0, oe_n_o=0 and we_n_o=1 for exactly RD_CYC cycles. RD_CYC is the largest of ceil(read cycle / period), ceil(address access / period) and ceil(output-enable access / period). The default is 2.
- R3: Read data is sampled from mem_din_i only on the last cycle of the output-enable window. It appears on rdata_o while done_o is 1 and stays there until the next read completes.
- R4: A write accepted with wr_i=1 holds we_n_o=0 for exactly WP_CYC cycles, with cs_n_o=0 and oe_n_o=1 throughout. WP_CYC is the largest of ceil(write pulse / period) and ceil(address-to-end-of-write / period). The default is 2.
- R5: mem_dout_en_o is 1 for exactly WP_CYC+1 cycles per write: the write-enable window plus one hold cycle. While it is 1, mem_dout_o equals the accepted write data. It is never 1 while oe_n_o is 0.
- R6: A write keeps cs_n_o=0 for WP_CYC+HOLD_CYC cycles, where HOLD_CYC = max(1, ceil(write cycle / period) - WP_CYC). It is followed by TURN_CYC cycles with ready_o=0 and cs_n_o=1, where TURN_CYC = max(1, ceil(write recovery / period)). The default for both is 1, so cs_n_o is high for at least 2 cycles between a write and the next access.
- R7: Whenever cs_n_o is 1, oe_n_o and we_n_o are 1 and mem_dout_en_o is 0. Between two reads, cs_n_o is 1 for at least one cycle.
- R8: mem_addr_o equals the accepted address and stays unchanged for as long as cs_n_o is 0, whatever addr_i does.
- R9: A request presented while ready_o is 0 is ignored. It starts no access, changes neither mem_addr_o nor memory contents, and leaves no pending request behind.
- R10: done_o is a one-cycle pulse given exactly once per accepted access. For a read it is high in the cycle after the output-enable window. For a write it is high in the first turnaround cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Host request; accepted on an edge where ready_o is 1 |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Host address |
| wdata_i | input | DATA_W | Host write data |
| ready_o | output | 1 | Controller idle and able to accept a request |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | DATA_W | Last captured read data |
| mem_addr_o | output | ADDR_W | Memory address bus |
| cs_n_o | output | 1 | Memory chip select, active low |
| oe_n_o | output | 1 | Memory output enable, active low |
| we_n_o | output | 1 | Memory write enable, active low |
| mem_dout_o | output | DATA_W | Data toward the memory |
| mem_dout_en_o | output | 1 | Drive enable for the data pad |
| mem_din_i | input | DATA_W | Data from the memory |

## Verification
A corrupted sequencer state shows up at the strobes within one cycle. A stuck or skipped count lengthens or shortens an output-enable or write-enable window, and a wrong state shows as a strobe low while chip select is high, or as data driven against an enabled output. The bench model returns the inverse of the stored byte on every cycle except the last cycle of the output-enable window. A capture taken one cycle early therefore reaches rdata_o as a wrong byte by the following done pulse. Failures of address hold, turnaround gaps and ignored busy requests appear as wrong window counts, wrong gap counts or extra chip-select activity on the very access where they occur.

// File: rtl/sram_ctrl_pkg.sv
// Package: shared types and elaboration-time helpers for the SRAM controller.
// Assumes all timing arguments are positive integers in picoseconds.
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE,
        ST_HOLD,
        ST_TURN
    } seq_state_e;

    // Cycles needed to cover a time span, rounded up.
    function automatic int ceil_cycles(input int span_ps, input int period_ps);
        return (span_ps + period_ps - 1) / period_ps;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        return max2(a, max2(b, c));
    endfunction

endpackage

// File: rtl/sram_cycle_timer.sv
// Module: down-counter that times each strobe window of the sequencer.
// Assumes load values are the window length minus one; zero_o marks the last cycle.
module sram_cycle_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             zero_o
);

    logic [CNT_W-1:0] cnt_q;

    // Load a new window length or count down towards zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);

    // Once expired, the timer stays expired until reloaded.
    assert_timer_parks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_o && !load_i) |=> zero_o);

endmodule

// File: rtl/sram_seq_fsm.sv
// Module: access sequencer; owns the registered strobes and data-drive enable.
// Assumes window lengths of at least one cycle and a timer that flags the last cycle.
module sram_seq_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int RD_CYC   = 2,
    parameter int WP_CYC   = 2,
    parameter int HOLD_CYC = 1,
    parameter int TURN_CYC = 1,
    parameter int CNT_W    = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic             wr_i,
    input  logic             tmr_zero_i,
    output logic             tmr_load_o,
    output logic [CNT_W-1:0] tmr_val_o,
    output logic             accept_o,
    output logic             capture_o,
    output logic             ready_o,
    output logic             done_o,
    output logic             cs_n_o,
    output logic             oe_n_o,
    output logic             we_n_o,
    output logic             drv_o
);

    seq_state_e st_q, st_d;
    logic cs_d, oe_d, we_d, drv_d, done_d;

    // Next state, timer loads and next strobe levels.
    always_comb begin
        st_d       = st_q;
        tmr_load_o = 1'b0;
        tmr_val_o  = '0;
        accept_o   = 1'b0;
        capture_o  = 1'b0;
        cs_d       = cs_n_o;
        oe_d       = oe_n_o;
        we_d       = we_n_o;
        drv_d      = drv_o;
        done_d     = 1'b0;
        case (st_q)
            ST_IDLE: begin
                if (req_i) begin
                    accept_o   = 1'b1;
                    tmr_load_o = 1'b1;
                    cs_d       = 1'b0;
                    if (wr_i) begin
                        st_d      = ST_WRITE;
                        tmr_val_o = CNT_W'(WP_CYC - 1);
                        we_d      = 1'b0;
                        drv_d     = 1'b1;
                    end else begin
                        st_d      = ST_READ;
                        tmr_val_o = CNT_W'(RD_CYC - 1);
                        oe_d      = 1'b0;
                    end
                end
            end
            ST_READ: begin
                if (tmr_zero_i) begin
                    capture_o = 1'b1;
                    cs_d      = 1'b1;
                    oe_d      = 1'b1;
                    done_d    = 1'b1;
                    st_d      = ST_IDLE;
                end
            end
            ST_WRITE: begin
                if (tmr_zero_i) begin
                    we_d       = 1'b1;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = CNT_W'(HOLD_CYC - 1);
                    st_d       = ST_HOLD;
                end
            end
            ST_HOLD: begin
                drv_d = 1'b0;
                if (tmr_zero_i) begin
                    cs_d       = 1'b1;
                    done_d     = 1'b1;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = CNT_W'(TURN_CYC - 1);
                    st_d       = ST_TURN;
                end
            end
            ST_TURN: begin
                if (tmr_zero_i) begin
                    st_d = ST_IDLE;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // Register the state and every memory-side strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            cs_n_o <= 1'b1;
            oe_n_o <= 1'b1;
            we_n_o <= 1'b1;
            drv_o  <= 1'b0;
            done_o <= 1'b0;
        end else begin
            st_q   <= st_d;
            cs_n_o <= cs_d;
            oe_n_o <= oe_d;
            we_n_o <= we_d;
            drv_o  <= drv_d;
            done_o <= done_d;
        end
    end

    assign ready_o = (st_q == ST_IDLE);

    // Window length trackers used only by the checks below.
    logic [7:0] oe_run_q, we_run_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_run_q <= '0;
            we_run_q <= '0;
        end else begin
            oe_run_q <= oe_n_o ? 8'd0 : oe_run_q + 8'd1;
            we_run_q <= we_n_o ? 8'd0 : we_run_q + 8'd1;
        end
    end

    assert_oe_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe_n_o) |-> (oe_run_q == 8'(RD_CYC)));

    assert_we_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n_o) |-> (we_run_q == 8'(WP_CYC)));

    assert_write_strobes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n_o |-> (oe_n_o && !cs_n_o && drv_o));

    assert_no_contention_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n_o |-> !drv_o);

    assert_deselect_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> (oe_n_o && we_n_o && !drv_o));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

endmodule

// File: rtl/sram_data_path.sv
// Module: address, write-data and read-data registers of the SRAM controller.
// Assumes accept and capture pulses come from the sequencer, one cycle each.
module sram_data_path #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept_i,
    input  logic              wr_i,
    input  logic              capture_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W-1:0] mem_din_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_dout_o,
    output logic [DATA_W-1:0] rdata_o
);

    // Latch address and write data when a request is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr_o <= '0;
            mem_dout_o <= '0;
        end else if (accept_i) begin
            mem_addr_o <= addr_i;
            if (wr_i) begin
                mem_dout_o <= wdata_i;
            end
        end
    end

    // Sample the memory data on the last cycle of a read window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_o <= '0;
        end else if (capture_i) begin
            rdata_o <= mem_din_i;
        end
    end

    assert_rdata_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !capture_i |=> $stable(rdata_o));

endmodule

// File: rtl/sram_bus_ctrl.sv
// Module: top of the asynchronous SRAM controller; derives cycle counts from
// picosecond timings and connects sequencer, timer and data path.
// Assumes one byte-wide device, split data pins, and a host that drops req_i
// once its request has been accepted.
module sram_bus_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W          = 8,
    parameter int DATA_W          = 8,
    parameter int CLK_PERIOD_PS   = 4000,
    parameter int RD_CYCLE_PS     = 8000,
    parameter int ADDR_ACCESS_PS  = 8000,
    parameter int OE_ACCESS_PS    = 4000,
    parameter int WR_CYCLE_PS     = 8000,
    parameter int WR_PULSE_PS     = 6000,
    parameter int ADDR_TO_WEND_PS = 6000,
    parameter int WR_RECOVER_PS   = 3000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              ready_o,
    output logic              done_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              cs_n_o,
    output logic              oe_n_o,
    output logic              we_n_o,
    output logic [DATA_W-1:0] mem_dout_o,
    output logic              mem_dout_en_o,
    input  logic [DATA_W-1:0] mem_din_i
);

    localparam int RD_CYC = max2(1, max3(ceil_cycles(RD_CYCLE_PS, CLK_PERIOD_PS),
                                         ceil_cycles(ADDR_ACCESS_PS, CLK_PERIOD_PS),
                                         ceil_cycles(OE_ACCESS_PS, CLK_PERIOD_PS)));
    localparam int WP_CYC = max2(1, max2(ceil_cycles(WR_PULSE_PS, CLK_PERIOD_PS),
                                         ceil_cycles(ADDR_TO_WEND_PS, CLK_PERIOD_PS)));
    localparam int WC_CYC   = ceil_cycles(WR_CYCLE_PS, CLK_PERIOD_PS);
    localparam int HOLD_CYC = max2(1, WC_CYC - WP_CYC);
    localparam int TURN_CYC = max2(1, ceil_cycles(WR_RECOVER_PS, CLK_PERIOD_PS));
    localparam int MAX_CYC  = max2(max2(RD_CYC, WP_CYC), max2(HOLD_CYC, TURN_CYC));
    localparam int CNT_W    = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

    logic             tmr_load, tmr_zero, accept, capture;
    logic [CNT_W-1:0] tmr_val;

    sram_cycle_timer #(.CNT_W(CNT_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .zero_o     (tmr_zero)
    );

    sram_seq_fsm #(
        .RD_CYC   (RD_CYC),
        .WP_CYC   (WP_CYC),
        .HOLD_CYC (HOLD_CYC),
        .TURN_CYC (TURN_CYC),
        .CNT_W    (CNT_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req_i),
        .wr_i       (wr_i),
        .tmr_zero_i (tmr_zero),
        .tmr_load_o (tmr_load),
        .tmr_val_o  (tmr_val),
        .accept_o   (accept),
        .capture_o  (capture),
        .ready_o    (ready_o),
        .done_o     (done_o),
        .cs_n_o     (cs_n_o),
        .oe_n_o     (oe_n_o),
        .we_n_o     (we_n_o),
        .drv_o      (mem_dout_en_o)
    );

    sram_data_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_data (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept_i   (accept),
        .wr_i       (wr_i),
        .capture_i  (capture),
        .addr_i     (addr_i),
        .wdata_i    (wdata_i),
        .mem_din_i  (mem_din_i),
        .mem_addr_o (mem_addr_o),
        .mem_dout_o (mem_dout_o),
        .rdata_o    (rdata_o)
    );

    assert_addr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n_o && $past(!cs_n_o)) |-> $stable(mem_addr_o));

    assert_busy_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !ready_o && cs_n_o) |=> cs_n_o);

endmodule

// File: tb/sim_sram_bus_ctrl.sv
// Bench: full address sweep of writes then reads against a behavioural SRAM,
// then write/read interleaving and busy-request probes.
module sim_sram_bus_ctrl;

    localparam int CLK_PS = 4000;
    localparam int RD_EXP = 2;    // ceil(8000/4000), ceil(8000/4000), ceil(4000/4000)
    localparam int WP_EXP = 2;    // ceil(6000/4000), ceil(6000/4000)
    localparam int HOLD_EXP = 1;  // max(1, 2 - 2)
    localparam int TURN_EXP = 1;  // max(1, ceil(3000/4000))

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0, wr = 1'b0;
    logic [7:0] addr = '0, wdata = '0;
    logic ready, done, cs_n, oe_n, we_n, dout_en;
    logic [7:0] rdata, mem_addr, mem_dout, mem_din;

    int vectors = 0, fails = 0, cyc = 0, dones = 0, accesses = 0;
    int hi_run = 0, oe_lo = 0;
    logic [7:0] model [256];
    logic [7:0] expect_mem [256];
    bit last_write = 1'b0;

    always #2ns clk = ~clk;

    sram_bus_ctrl #(.CLK_PERIOD_PS(CLK_PS)) u0 (
        .clk(clk), .rst_n(rst_n), .req_i(req), .wr_i(wr), .addr_i(addr),
        .wdata_i(wdata), .ready_o(ready), .done_o(done), .rdata_o(rdata),
        .mem_addr_o(mem_addr), .cs_n_o(cs_n), .oe_n_o(oe_n), .we_n_o(we_n),
        .mem_dout_o(mem_dout), .mem_dout_en_o(dout_en), .mem_din_i(mem_din)
    );

    // Behavioural SRAM: valid data only on the last output-enable cycle.
    assign mem_din = (!cs_n && !oe_n && oe_lo == RD_EXP - 1) ? model[mem_addr]
                                                             : ~model[mem_addr];

    always @(posedge clk) begin
        if (!cs_n && !we_n && dout_en) model[mem_addr] <= mem_dout;
        hi_run <= cs_n ? hi_run + 1 : 0;
        oe_lo  <= oe_n ? 0 : oe_lo + 1;
        if (rst_n && done) dones <= dones + 1;
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            fails = fails + 1;
            $display("FAIL watchdog R10: actual %0d cycles, expected completion", cyc);
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        vectors = vectors + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    // One access; poke=1 raises a stray write request while the block is busy.
    task automatic access(input bit w, input logic [7:0] a, input logic [7:0] d,
                          input bit poke);
        int n_cs = 0, n_oe = 0, n_we = 0, n_drv = 0;
        int bad_addr = 0, bad_dout = 0, bad_we = 0, guard = 0, gap;
        while (!ready) @(negedge clk);
        req = 1'b1; wr = w; addr = a; wdata = d;
        @(negedge clk);
        req = 1'b0; addr = ~a; wdata = ~d;
        gap = hi_run;
        if (accesses > 0)
            chk(gap >= (last_write ? 1 + TURN_EXP : 1), last_write ? "R6 gap" : "R7 gap",
                gap, last_write ? 1 + TURN_EXP : 1);
        accesses = accesses + 1;
        while (!done && guard < 50) begin
            if (!cs_n) n_cs++;
            if (!oe_n) n_oe++;
            if (!we_n) n_we++;
            if (dout_en) n_drv++;
            if (!cs_n && mem_addr != a) bad_addr++;
            if (dout_en && (mem_dout != d || !oe_n)) bad_dout++;
            if (!we_n && (oe_n != 1'b1 || cs_n != 1'b0)) bad_we++;
            if (poke && guard == 0) begin req = 1'b1; wr = 1'b1; addr = a ^ 8'h01; end
            if (poke && guard == 1) begin req = 1'b0; addr = ~a; end
            guard++;
            @(negedge clk);
        end
        chk(bad_addr == 0, "R8 address hold", bad_addr, 0);
        chk(cs_n && oe_n && we_n && !dout_en, "R7 strobes idle at done", cs_n, 1);
        if (w) begin
            chk(n_we == WP_EXP, "R4 write pulse", n_we, WP_EXP);
            chk(bad_we == 0, "R4 strobe levels", bad_we, 0);
            chk(n_drv == WP_EXP + 1, "R5 drive cycles", n_drv, WP_EXP + 1);
            chk(bad_dout == 0, "R5 drive data", bad_dout, 0);
            chk(n_cs == WP_EXP + HOLD_EXP, "R6 write cs", n_cs, WP_EXP + HOLD_EXP);
            chk(!ready, "R6 turnaround ready", ready, 0);
            expect_mem[a] = d;
        end else begin
            chk(n_oe == RD_EXP && n_cs == RD_EXP, "R2 read window", n_oe, RD_EXP);
            chk(n_drv == 0, "R5 no drive on read", n_drv, 0);
            chk(rdata == expect_mem[a], "R3 read data", rdata, expect_mem[a]);
        end
        last_write = w;
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin model[i] = '0; expect_mem[i] = '0; end
        repeat (3) @(negedge clk);
        chk(cs_n && oe_n && we_n && !dout_en && !done, "R1 reset strobes", cs_n, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cs_n && oe_n && we_n && !dout_en && ready && !done, "R1 after reset",
            ready, 1);
        // R4/R5/R6: write every address.
        for (int a = 0; a < 256; a++) access(1'b1, 8'(a), 8'((a * 37 + 11) & 255), 1'b0);
        // R2/R3/R7: back-to-back reads of every address.
        for (int a = 0; a < 256; a++) access(1'b0, 8'(a), 8'h00, 1'b0);
        // R6: write immediately followed by read.
        for (int a = 0; a < 32; a++) begin
            access(1'b1, 8'(a * 7), 8'(a ^ 8'h5A), 1'b0);
            access(1'b0, 8'(a * 7), 8'h00, 1'b0);
        end
        // R9: stray request during a busy read must start nothing.
        for (int k = 0; k < 4; k++) begin
            access(1'b0, 8'(k * 16 + 2), 8'h00, 1'b1);
            for (int j = 0; j < 3; j++) begin
                @(negedge clk);
                chk(cs_n && ready, "R9 no stray access", cs_n, 1);
            end
            access(1'b0, 8'(k * 16 + 3), 8'h00, 1'b0);
            chk(model[8'(k * 16 + 3)] == expect_mem[8'(k * 16 + 3)], "R9 memory untouched",
                model[8'(k * 16 + 3)], expect_mem[8'(k * 16 + 3)]);
        end
        @(negedge clk);
        chk(dones == accesses, "R10 one done per access", dones, accesses);
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule